// File: doc/BRIEF.md
# Configuration Space Register Responder

This block answers configuration reads and writes for a small set of device/function slots inside one component. Each request names a device number, a function number, a dword register index and four byte enables, so 8, 16 and 32 bit accesses all travel the same path. Every implemented slot exposes three registers: an identification word, a control word and a status word. All other indices in an implemented slot are reserved locations. A slot with no function behind it looks empty to enumeration software.

There are two synchronous, active-high reset inputs. The hard reset returns ordinary fields to their defaults. The power-good reset does the same and also clears the sticky status field, which a hard reset leaves alone. Two strap inputs shape the reset state. One supplies the default of the control mode field. The other, together with a parameter, decides whether the optional fourth slot exists.

Requests are strobed for one cycle each and may come back to back. Every accepted request is acknowledged exactly one clock later, and the read word is presented in that same cycle.

Top module: `cfg_space_responder`

## Requirements
- R1: Register index 0 of an implemented slot reads {device ID, vendor ID}, with vendor ID 16'h1D5A in bits [15:0]. The device ID is 16'hA100 | (dev<<4) | fn. The implemented slots are (dev 0, fn 0), (dev 0, fn 1), (dev 1, fn 0) and the optional (dev 1, fn 2). Writes to index 0 are ignored.
- R2: A request to a device/function pair with no implemented slot is acknowledged. Index 0 reads 32'hFFFF_FFFF, every other index reads zero, and writes change nothing.
- R3: The optional slot (dev 1, fn 2) is present only while parameter OPT_SLOT_EN is 1 and strap_opt_en is 1. While it is absent, it behaves as an unimplemented slot, and writes aimed at it leave its registers untouched.
- R4: Register indices 3 to 63 of an implemented slot are reserved. They are acknowledged normally, read zero under any byte-enable pattern, and writes to them alter no register.
- R5: Reserved bits inside implemented registers always read zero and ignore writes. These are control bits [15:8] and [31:24], and status bits [31:16].
- R6: On a write to control (index 1) or status (index 2), byte lane k (bits [8k+7:8k]) is updated only when req_be[k] is 1. The other lanes keep their values.
- R7: After either reset, control bits [7:0] equal strap_mode and control bits [23:16] equal 8'h40.
- R8: Status bits [15:8] are cleared by either reset. Status bits [7:0] are sticky: a hard reset leaves them unchanged.
- R9: A power-good reset clears status bits [7:0] to zero.
- R10: For a request strobed in a cycle with both resets low, ack is high for exactly the next cycle, and rdata then holds the addressed word as it was before that request. During reset ack and rdata are 0. A request strobed in a reset cycle is dropped: it gets no ack and performs no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_hard | input | 1 | Synchronous hard reset, active high; spares sticky bits |
| rst_pwrgood | input | 1 | Synchronous power-good reset, active high; clears everything |
| strap_mode | input | 8 | Reset default for control bits [7:0] |
| strap_opt_en | input | 1 | Enables the optional slot |
| req_valid | input | 1 | One-cycle request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dev | input | 5 | Device number |
| req_fn | input | 3 | Function number |
| req_reg | input | 6 | Dword register index |
| req_be | input | 4 | Byte enables, bit k selects lane k |
| req_wdata | input | 32 | Write data |
| ack | output | 1 | One-cycle acknowledge |
| rdata | output | 32 | Read word, valid while ack is high |

## Verification
A write to the status word can arrive in the same cycle as a hard reset. The sticky field is then pulled two ways: it must survive the reset, and the write would change it. The bench raises the strobe and rst_hard on the same falling edge, with a status pattern that differs from the stored one. It judges the outcome in two steps. First, no acknowledge may appear. Second, a later read must show the sticky byte unchanged and the ordinary byte cleared, which proves the write was dropped and not merged.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    localparam int DEV_W     = 5;
    localparam int FN_W      = 3;
    localparam int REG_W     = 6;
    localparam int DATA_W    = 32;
    localparam int LANES     = DATA_W / 8;
    localparam int NUM_SLOTS = 4;
    localparam int OPT_SLOT  = NUM_SLOTS - 1;

    localparam logic [15:0]       VENDOR_ID    = 16'h1D5A;
    localparam logic [15:0]       DID_BASE     = 16'hA100;
    localparam logic [7:0]        THRESH_DFLT  = 8'h40;
    localparam logic [DATA_W-1:0] CTRL_WMASK   = 32'h00FF_00FF;
    localparam logic [DATA_W-1:0] STICKY_WMASK = 32'h0000_00FF;
    localparam logic [DATA_W-1:0] LIVE_WMASK   = 32'h0000_FF00;

    typedef enum logic [1:0] {
        SEL_ID,
        SEL_CTRL,
        SEL_STAT,
        SEL_RSVD
    } reg_sel_e;

    typedef struct packed {
        logic              wr;
        logic [DEV_W-1:0]  dev;
        logic [FN_W-1:0]   fn;
        logic [REG_W-1:0]  idx;
        logic [LANES-1:0]  be;
        logic [DATA_W-1:0] wdata;
    } cfg_req_t;

    function automatic logic [DEV_W-1:0] slot_dev(input int s);
        return (s < 2) ? DEV_W'(0) : DEV_W'(1);
    endfunction

    function automatic logic [FN_W-1:0] slot_fn(input int s);
        case (s)
            1:       return FN_W'(1);
            3:       return FN_W'(2);
            default: return FN_W'(0);
        endcase
    endfunction

    function automatic logic [15:0] slot_did(input int s);
        return DID_BASE | (16'(slot_dev(s)) << 4) | 16'(slot_fn(s));
    endfunction

    // Update only the enabled byte lanes that are also writable.
    function automatic logic [DATA_W-1:0] lane_merge(
        input logic [DATA_W-1:0] cur,
        input logic [DATA_W-1:0] wd,
        input logic [LANES-1:0]  be,
        input logic [DATA_W-1:0] wmask
    );
        logic [DATA_W-1:0] m;
        for (int k = 0; k < LANES; k++) m[8*k +: 8] = {8{be[k]}};
        m = m & wmask;
        return (cur & ~m) | (wd & m);
    endfunction

endpackage

// File: rtl/cfg_decode.sv
module cfg_decode
    import cfg_pkg::*;
(
    input  logic [DEV_W-1:0]     dev,
    input  logic [FN_W-1:0]      fn,
    input  logic [REG_W-1:0]     idx,
    input  logic                 opt_present,
    output logic [NUM_SLOTS-1:0] slot_hit,
    output reg_sel_e             sel
);

    always_comb begin
        for (int s = 0; s < NUM_SLOTS; s++) begin
            slot_hit[s] = (dev == slot_dev(s)) && (fn == slot_fn(s))
                          && ((s != OPT_SLOT) || opt_present);
        end
        case (idx)
            REG_W'(0): sel = SEL_ID;
            REG_W'(1): sel = SEL_CTRL;
            REG_W'(2): sel = SEL_STAT;
            default:   sel = SEL_RSVD;
        endcase
    end

    // R1
    always_comb begin
        slot_onehot_chk: assert ($onehot0(slot_hit));
    end

endmodule

// File: rtl/cfg_func_regs.sv
module cfg_func_regs
    import cfg_pkg::*;
#(
    parameter logic [15:0] DEV_ID = 16'hA100
) (
    input  logic              clk,
    input  logic              rst_hard,
    input  logic              rst_pwrgood,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [LANES-1:0]  be,
    input  logic [DATA_W-1:0] wdata,
    input  logic [7:0]        strap_mode,
    output logic [DATA_W-1:0] rd_word
);

    logic [DATA_W-1:0] ctrl_q, stky_q, live_q;
    logic              wr_ctrl, wr_stat, rst_any;

    assign rst_any = rst_hard || rst_pwrgood;
    assign wr_ctrl = wr_en && (sel == SEL_CTRL);
    assign wr_stat = wr_en && (sel == SEL_STAT);

    // ordinary fields: either reset
    always_ff @(posedge clk) begin
        if (rst_any) begin
            ctrl_q <= {8'h00, THRESH_DFLT, 8'h00, strap_mode};
            live_q <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= lane_merge(ctrl_q, wdata, be, CTRL_WMASK);
            if (wr_stat) live_q <= lane_merge(live_q, wdata, be, LIVE_WMASK);
        end
    end

    // sticky field: power-good reset only
    always_ff @(posedge clk) begin
        if (rst_pwrgood)
            stky_q <= '0;
        else if (wr_stat && !rst_hard)
            stky_q <= lane_merge(stky_q, wdata, be, STICKY_WMASK);
    end

    always_comb begin
        case (sel)
            SEL_ID:   rd_word = {DEV_ID, VENDOR_ID};
            SEL_CTRL: rd_word = ctrl_q;
            SEL_STAT: rd_word = stky_q | live_q;
            default:  rd_word = '0;
        endcase
    end

    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst_pwrgood)
        rst_hard |=> $stable(stky_q));

    // R9
    sticky_clear_chk: assert property (@(posedge clk)
        rst_pwrgood |=> (stky_q == '0));

    // R4
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst_any)
        !wr_ctrl |=> $stable(ctrl_q));

endmodule

// File: rtl/cfg_space_responder.sv
module cfg_space_responder
    import cfg_pkg::*;
#(
    parameter bit OPT_SLOT_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_hard,
    input  logic              rst_pwrgood,
    input  logic [7:0]        strap_mode,
    input  logic              strap_opt_en,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [FN_W-1:0]   req_fn,
    input  logic [REG_W-1:0]  req_reg,
    input  logic [LANES-1:0]  req_be,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rdata
);

    cfg_req_t             req;
    logic [NUM_SLOTS-1:0] slot_hit;
    reg_sel_e             sel;
    logic [DATA_W-1:0]    slot_rd [NUM_SLOTS];
    logic [DATA_W-1:0]    rd_mux;
    logic                 rst_any, acc_ok, any_hit, opt_present;

    assign req = '{wr: req_write, dev: req_dev, fn: req_fn, idx: req_reg,
                   be: req_be, wdata: req_wdata};

    assign rst_any     = rst_hard || rst_pwrgood;
    assign acc_ok      = req_valid && !rst_any;
    assign opt_present = OPT_SLOT_EN && strap_opt_en;
    assign any_hit     = |slot_hit;

    cfg_decode u_decode (
        .dev         (req.dev),
        .fn          (req.fn),
        .idx         (req.idx),
        .opt_present (opt_present),
        .slot_hit    (slot_hit),
        .sel         (sel)
    );

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        cfg_func_regs #(.DEV_ID(slot_did(s))) u_regs (
            .clk         (clk),
            .rst_hard    (rst_hard),
            .rst_pwrgood (rst_pwrgood),
            .wr_en       (acc_ok && req.wr && slot_hit[s]),
            .sel         (sel),
            .be          (req.be),
            .wdata       (req.wdata),
            .strap_mode  (strap_mode),
            .rd_word     (slot_rd[s])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (slot_hit[s]) rd_mux = rd_mux | slot_rd[s];
        end
        if (!any_hit && (sel == SEL_ID)) rd_mux = '1;
    end

    always_ff @(posedge clk) begin
        if (rst_any) begin
            ack   <= 1'b0;
            rdata <= '0;
        end else begin
            ack   <= req_valid;
            rdata <= req_valid ? rd_mux : '0;
        end
    end

    // R10
    ack_follow_chk: assert property (@(posedge clk) disable iff (rst_any)
        req_valid |=> ack);

    // R10
    ack_idle_chk: assert property (@(posedge clk) disable iff (rst_any)
        !req_valid |=> !ack);

    // R4
    rsvd_read_chk: assert property (@(posedge clk) disable iff (rst_any)
        (ack && $past(req_valid && any_hit && sel == SEL_RSVD)) |-> (rdata == '0));

    // R2
    empty_id_chk: assert property (@(posedge clk) disable iff (rst_any)
        (ack && $past(req_valid && !any_hit && req_reg == '0)) |-> (rdata == '1));

endmodule

// File: tb/cfg_space_responder_bench.sv
module cfg_space_responder_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_hard, rst_pwrgood;
    logic [7:0]  strap_mode;
    logic        strap_opt_en;
    logic        req_valid, req_write;
    logic [4:0]  req_dev;
    logic [2:0]  req_fn;
    logic [5:0]  req_reg;
    logic [3:0]  req_be;
    logic [31:0] req_wdata;
    logic        ack;
    logic [31:0] rdata;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] m_ctrl [4];
    logic [31:0] m_stky [4];
    logic [31:0] m_live [4];
    bit          opt_on;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_space_responder u_cfg_space_responder (
        .clk, .rst_hard, .rst_pwrgood, .strap_mode, .strap_opt_en,
        .req_valid, .req_write, .req_dev, .req_fn, .req_reg, .req_be,
        .req_wdata, .ack, .rdata
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int slot_of(input int d, input int f);
        if (d == 0 && f == 0) return 0;
        if (d == 0 && f == 1) return 1;
        if (d == 1 && f == 0) return 2;
        if (d == 1 && f == 2 && opt_on) return 3;
        return -1;
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] cur, input logic [31:0] wd,
                                          input logic [3:0] be, input logic [31:0] wm);
        logic [31:0] r;
        r = cur;
        for (int k = 0; k < 4; k++)
            if (be[k])
                for (int b = 0; b < 8; b++)
                    if (wm[8*k+b]) r[8*k+b] = wd[8*k+b];
        return r;
    endfunction

    function automatic logic [31:0] model_read(input int d, input int f, input int r);
        int s;
        s = slot_of(d, f);
        if (s < 0) return (r == 0) ? 32'hFFFF_FFFF : 32'h0;
        case (r)
            0:       return {16'hA100 | 16'(d << 4) | 16'(f), 16'h1D5A};
            1:       return m_ctrl[s];
            2:       return m_stky[s] | m_live[s];
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_write(input int d, input int f, input int r,
                               input logic [3:0] be, input logic [31:0] wd);
        int s;
        s = slot_of(d, f);
        if (s < 0) return;
        if (r == 1) m_ctrl[s] = merge(m_ctrl[s], wd, be, 32'h00FF_00FF);
        if (r == 2) begin
            m_stky[s] = merge(m_stky[s], wd, be, 32'h0000_00FF);
            m_live[s] = merge(m_live[s], wd, be, 32'h0000_FF00);
        end
    endtask

    task automatic model_reset(input bit pg);
        for (int s = 0; s < 4; s++) begin
            m_ctrl[s] = {8'h00, 8'h40, 8'h00, strap_mode};
            m_live[s] = 32'h0;
            if (pg) m_stky[s] = 32'h0;
        end
    endtask

    task automatic do_reset(input bit pg);
        @(negedge clk);
        rst_hard = 1'b1;
        rst_pwrgood = pg;
        @(negedge clk);
        rst_hard = 1'b0;
        rst_pwrgood = 1'b0;
        model_reset(pg);
    endtask

    task automatic access(input bit wr, input int d, input int f, input int r,
                          input logic [3:0] be, input logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_dev   = 5'(d);
        req_fn    = 3'(f);
        req_reg   = 6'(r);
        req_be    = be;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 ack", {31'h0, ack}, 32'h1);
    endtask

    task automatic rd(input string tag, input int d, input int f, input int r, input logic [3:0] be);
        access(1'b0, d, f, r, be, 32'h0);
        check(tag, rdata, model_read(d, f, r));
    endtask

    task automatic wr(input int d, input int f, input int r,
                      input logic [3:0] be, input logic [31:0] wd);
        logic [31:0] old;
        old = model_read(d, f, r);
        access(1'b1, d, f, r, be, wd);
        check("R10 pre-write rdata", rdata, old);
        model_write(d, f, r, be, wd);
    endtask

    task automatic read_sweep(input string tag);
        for (int d = 0; d < 4; d++)
            for (int f = 0; f < 8; f++)
                for (int r = 0; r < 5; r++)
                    rd(tag, d, f, r, 4'hF);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_hard = 1'b1; rst_pwrgood = 1'b1;
        strap_mode = 8'h5C; strap_opt_en = 1'b1; opt_on = 1'b1;
        req_valid = 1'b0; req_write = 1'b0; req_dev = '0; req_fn = '0;
        req_reg = '0; req_be = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        rst_hard = 1'b0; rst_pwrgood = 1'b0;
        model_reset(1'b1);

        // R10 reset state
        check("R10 reset ack", {31'h0, ack}, 32'h0);
        check("R10 reset rdata", rdata, 32'h0);

        // R1 R2 R4 R7: sweep over slots and indices after reset
        read_sweep("R1/R2/R4/R7 read sweep");

        // R6 R5 R8: every byte-enable pattern on control and status
        for (int s = 0; s < 4; s++)
            for (int r = 1; r < 3; r++)
                for (int be = 0; be < 16; be++) begin
                    int d, f;
                    d = (s < 2) ? 0 : 1;
                    f = (s == 1) ? 1 : ((s == 3) ? 2 : 0);
                    wr(d, f, r, 4'(be), 32'h8C4B_1E97 ^ (32'h0101_0101 * 32'(be)));
                    rd("R6/R5 lane merge", d, f, r, 4'hF);
                end

        // R4 R2 R1: reserved, empty-slot and ID writes have no effect
        for (int d = 0; d < 4; d++)
            for (int f = 0; f < 8; f++) begin
                int regs [4] = '{0, 3, 17, 63};
                for (int i = 0; i < 4; i++) begin
                    wr(d, f, regs[i], 4'h1, 32'hFFFF_FFFF);
                    wr(d, f, regs[i], 4'h3, 32'hFFFF_FFFF);
                    wr(d, f, regs[i], 4'hF, 32'hFFFF_FFFF);
                    rd("R4 reserved read byte", d, f, regs[i], 4'h1);
                    rd("R4 reserved read half", d, f, regs[i], 4'hC);
                end
                if (slot_of(d, f) < 0) wr(d, f, 1, 4'hF, 32'h1234_5678);
            end
        read_sweep("R4/R2 after ignored writes");

        // R10 ack lasts one cycle
        @(negedge clk);
        check("R10 ack single cycle", {31'h0, ack}, 32'h0);

        // R8 R7: sticky survives hard reset, strap sets mode default
        wr(0, 0, 2, 4'h3, 32'h0000_A53C);
        wr(0, 1, 2, 4'hF, 32'h0000_5AA5);
        strap_mode = 8'h21;
        do_reset(1'b0);
        rd("R8 sticky after hard reset", 0, 0, 2, 4'hF);
        check("R8 sticky value", rdata, 32'h0000_003C);
        rd("R7 strap default", 0, 0, 1, 4'hF);
        check("R7 ctrl value", rdata, 32'h0040_0021);

        // R10 R8: write colliding with hard reset is dropped
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_dev = 5'd0; req_fn = 3'd1;
        req_reg = 6'd2; req_be = 4'hF; req_wdata = 32'h0000_7766;
        rst_hard = 1'b1;
        @(negedge clk);
        check("R10 no ack in reset", {31'h0, ack}, 32'h0);
        req_valid = 1'b0; rst_hard = 1'b0;
        model_reset(1'b0);
        rd("R8 collision sticky kept", 0, 1, 2, 4'hF);
        check("R8 collision value", rdata, 32'h0000_00A5);

        // R9: power-good reset clears sticky
        do_reset(1'b1);
        rd("R9 sticky cleared", 0, 1, 2, 4'hF);
        rd("R9 sticky cleared s0", 0, 0, 2, 4'hF);

        // R3: optional slot gated by strap
        wr(1, 2, 1, 4'hF, 32'h0011_0022);
        strap_opt_en = 1'b0; opt_on = 1'b0;
        rd("R3 absent id", 1, 2, 0, 4'hF);
        wr(1, 2, 1, 4'hF, 32'h00EE_00DD);
        rd("R3 absent ctrl", 1, 2, 1, 4'hF);
        strap_opt_en = 1'b1; opt_on = 1'b1;
        rd("R3 present id", 1, 2, 0, 4'hF);
        rd("R3 state kept", 1, 2, 1, 4'hF);
        check("R3 ctrl value", rdata, 32'h0011_0022);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule